// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block chooses the one interrupt cause that a 16550-style UART reports to the host. Five sources are considered, each gated by its own enable bit: receiver line errors, receive character timeout, received data available, transmit holding register empty, and modem-status change. The highest-priority active source sets the low nibble of the identification byte and raises a level interrupt line. When nothing enabled is active, the nibble reads "nothing pending" and the line is low.

The block also owns the transmit-empty pending flag. A host write to the holding register clears it. The transmitter draining sets it, and so does a host write to the enable register while the holding register is empty. A host read of the identification byte clears it, but only when that read returns the transmit-empty code. The identification byte is combinational, so a read returns the value from before its own side effect. The upper nibble shows whether the FIFOs are on. FIFO storage, shifters and baud generation live elsewhere. All pins are plain control and status levels or single-cycle strobes, so there is no stream handshake and no back-pressure.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the pending flag is 0, the identification nibble is 0x1 and `irq` is low.
- R2: If `ier_en[2]` is set and any bit of `lsr_err` is set, the nibble is 0x6. No other source can override this.
- R3: If `ier_en[0]` and `timeout_pend` are both set and R2 does not apply, the nibble is 0xC. The timeout has no enable bit of its own.
- R4: If `ier_en[0]` and `rx_ready` are set and either `fifo_on` is 0 or `rx_count` is at or above the trigger level, and neither R2 nor R3 applies, the nibble is 0x4.
- R5: `trig_sel` values 0, 1, 2 and 3 select trigger levels of 1, 4, 8 and 14 bytes (FIFO_DEPTH=16). A count one below the level raises no data interrupt.
- R6: If `ier_en[1]` and the pending flag are set and no higher source applies, the nibble is 0x2.
- R7: If `ier_en[3]` is set, any bit of `msr_delta` is set, and no higher source applies, the nibble is 0x0.
- R8: With no enabled active source the nibble is 0x1 and `irq` is low. Any other nibble drives `irq` high.
- R9: `iir_data[7:6]` are both equal to `fifo_on`, and `iir_data[5:4]` are 0.
- R10: A cycle with `iir_rd` high while the nibble is 0x2 clears the pending flag from the next cycle on. The data returned in that cycle still shows 0x2. A read of any other code leaves the flag as it was.
- R11: `thr_wr` clears the flag. `tx_drained`, or `ier_wr` with `thr_empty` high, sets it. In a single cycle the precedence is: write clears, then set, then read clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_en | input | 4 | Enables: [0] rx data/timeout, [1] tx empty, [2] line status, [3] modem |
| ier_wr | input | 1 | Strobe: host wrote the enable register |
| lsr_err | input | 4 | Break, framing, parity and overrun status bits |
| rx_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| trig_sel | input | 2 | Trigger level select |
| fifo_on | input | 1 | FIFOs enabled |
| timeout_pend | input | 1 | Character timeout pending |
| thr_wr | input | 1 | Strobe: host wrote the holding register |
| thr_empty | input | 1 | Holding register currently empty |
| tx_drained | input | 1 | Strobe: transmitter emptied the holding register |
| msr_delta | input | 4 | Modem-status change bits |
| iir_rd | input | 1 | Strobe: host reads the identification byte this cycle |
| iir_data | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt |
| thre_pend | output | 1 | Transmit-empty pending flag |

## Verification
The case that is hardest to reach from the ports is a read of the identification byte that returns 0x2 in the same cycle as a set or clear event on the flag. The precedence of R11 only shows up in that exact overlap. The other hard cases are receive counts sitting exactly at, or one below, each trigger level. The stimulus runs directed sequences for the boundary counts and the overlapping strobes. It then runs a long stretch with the strobes and source bits toggled at random, biased so that the transmit-empty code is often on top when a read arrives. A behavioural model is compared on every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // Source index 0 is the highest priority.
  localparam int NUM_SRC = 5;

  function automatic irq_id_e src_code(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_TIMEOUT;
      2:       return ID_RXDATA;
      3:       return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [1:0]       trig_sel,
  output logic [CNT_W-1:0] level
);
  localparam int LVL0 = 1;
  localparam int LVL1 = FIFO_DEPTH / 4;
  localparam int LVL2 = FIFO_DEPTH / 2;
  localparam int LVL3 = FIFO_DEPTH - 2;

  always_comb begin
    case (trig_sel)
      2'd0:    level = CNT_W'(LVL0);
      2'd1:    level = CNT_W'(LVL1);
      2'd2:    level = CNT_W'(LVL2);
      default: level = CNT_W'(LVL3);
    endcase
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output irq_id_e            id
);
  always_comb begin
    id = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) id = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_thre_flag.sv
module uart_irq_thre_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic tx_drained,
  input  logic ier_wr,
  input  logic thr_empty,
  input  logic rd_thre,
  output logic pend
);
  logic set_evt;
  assign set_evt = tx_drained | (ier_wr & thr_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (thr_wr)  pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (rd_thre) pend <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier_en,
  input  logic             ier_wr,
  input  logic [3:0]       lsr_err,
  input  logic             rx_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             fifo_on,
  input  logic             timeout_pend,
  input  logic             thr_wr,
  input  logic             thr_empty,
  input  logic             tx_drained,
  input  logic [3:0]       msr_delta,
  input  logic             iir_rd,
  output logic [7:0]       iir_data,
  output logic             irq,
  output logic             thre_pend
);
  logic [CNT_W-1:0]   trig_level;
  logic [NUM_SRC-1:0] req;
  irq_id_e            cur_id;
  logic               rx_hit;

  uart_irq_trig #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_trig (
    .trig_sel (trig_sel),
    .level    (trig_level)
  );

  assign rx_hit = rx_ready & (~fifo_on | (rx_count >= trig_level));

  assign req[0] = ier_en[2] & (|lsr_err);
  assign req[1] = ier_en[0] & timeout_pend;
  assign req[2] = ier_en[0] & rx_hit;
  assign req[3] = ier_en[1] & thre_pend;
  assign req[4] = ier_en[3] & (|msr_delta);

  uart_irq_prio u_prio (
    .req (req),
    .id  (cur_id)
  );

  uart_irq_thre_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_wr     (thr_wr),
    .tx_drained (tx_drained),
    .ier_wr     (ier_wr),
    .thr_empty  (thr_empty),
    .rd_thre    (iir_rd && (cur_id == ID_THRE)),
    .pend       (thre_pend)
  );

  assign iir_data = {fifo_on, fifo_on, 2'b00, cur_id};
  assign irq      = (cur_id != ID_NONE);
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ier_en,
  input logic             ier_wr,
  input logic [3:0]       lsr_err,
  input logic             timeout_pend,
  input logic             thr_wr,
  input logic             thr_empty,
  input logic             tx_drained,
  input logic [3:0]       msr_delta,
  input logic             fifo_on,
  input logic             iir_rd,
  input logic [7:0]       iir_data,
  input logic             irq,
  input logic             thre_pend
);
  p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_en[2] && |lsr_err) |-> iir_data[3:0] == 4'h6);

  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_en[0] && timeout_pend && !(ier_en[2] && |lsr_err)) |-> iir_data[3:0] == 4'hC);

  p_modem_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_data[3:0] == 4'h0) |-> (ier_en[3] && |msr_delta));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_data[3:0] == 4'h1) |-> !irq);

  p_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iir_data[7:4] == {fifo_on, fifo_on, 2'b00});

  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_data[3:0] == 4'h2 && !tx_drained && !ier_wr) |=> !thre_pend);

  p_ier_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && thr_empty && !thr_wr) |=> thre_pend);

  p_wr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ier_en       (ier_en),
  .ier_wr       (ier_wr),
  .lsr_err      (lsr_err),
  .timeout_pend (timeout_pend),
  .thr_wr       (thr_wr),
  .thr_empty    (thr_empty),
  .tx_drained   (tx_drained),
  .msr_delta    (msr_delta),
  .fifo_on      (fifo_on),
  .iir_rd       (iir_rd),
  .iir_data     (iir_data),
  .irq          (irq),
  .thre_pend    (thre_pend)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ier_en = '0;
  logic       ier_wr = 1'b0;
  logic [3:0] lsr_err = '0;
  logic       rx_ready = 1'b0;
  logic [4:0] rx_count = '0;
  logic [1:0] trig_sel = '0;
  logic       fifo_on = 1'b0;
  logic       timeout_pend = 1'b0;
  logic       thr_wr = 1'b0;
  logic       thr_empty = 1'b0;
  logic       tx_drained = 1'b0;
  logic [3:0] msr_delta = '0;
  logic       iir_rd = 1'b0;
  logic [7:0] iir_data;
  logic       irq;
  logic       thre_pend;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit m_pend = 0;
  bit last_rd_thre = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier_en(ier_en), .ier_wr(ier_wr),
    .lsr_err(lsr_err), .rx_ready(rx_ready), .rx_count(rx_count),
    .trig_sel(trig_sel), .fifo_on(fifo_on), .timeout_pend(timeout_pend),
    .thr_wr(thr_wr), .thr_empty(thr_empty), .tx_drained(tx_drained),
    .msr_delta(msr_delta), .iir_rd(iir_rd), .iir_data(iir_data),
    .irq(irq), .thre_pend(thre_pend)
  );

  function automatic int lvl(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    if (sel == 2) return 8;
    return 14;
  endfunction

  function automatic int exp_code();
    if (ier_en[2] && lsr_err != 0) return 6;
    if (ier_en[0] && timeout_pend) return 12;
    if (ier_en[0] && rx_ready && (!fifo_on || int'(rx_count) >= lvl(trig_sel))) return 4;
    if (ier_en[1] && m_pend) return 2;
    if (ier_en[3] && msr_delta != 0) return 0;
    return 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Reference model of the pending flag.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pend = 0;
      last_rd_thre = 0;
    end else begin
      last_rd_thre = iir_rd && exp_code() == 2;
      if (thr_wr) m_pend = 0;
      else if (tx_drained || (ier_wr && thr_empty)) m_pend = 1;
      else if (last_rd_thre) m_pend = 0;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int c;
      string tg;
      c = exp_code();
      case (c)
        6: tg = "R2"; 12: tg = "R3"; 2: tg = "R6"; 0: tg = "R7"; 1: tg = "R8";
        default: tg = fifo_on ? "R5" : "R4";
      endcase
      chk(tg, int'(iir_data[3:0]), c);
      chk("R8", int'(irq), int'(c != 1));
      chk("R9", int'(iir_data[7:4]), fifo_on ? 'hC : 0);
      chk(last_rd_thre ? "R10" : "R11", int'(thre_pend), int'(m_pend));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
    ier_wr = 0; thr_wr = 0; tx_drained = 0; iir_rd = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R1", int'(iir_data[3:0]), 1);
    chk("R1", int'(irq), 0);
    chk("R1", int'(thre_pend), 0);
    rst_n = 1;
    step();
    // R11: enable write while the holding register is empty sets the flag.
    ier_en = 4'h2; ier_wr = 1; thr_empty = 1;
    step(2);
    // R10: read while 0x2 is shown clears the flag.
    @(negedge clk); chk("R10", int'(iir_data[3:0]), 2);
    iir_rd = 1; step(2);
    @(negedge clk); chk("R10", int'(thre_pend), 0);
    // R11: drain sets, write clears; read overlapping a set keeps it set.
    tx_drained = 1; step(); iir_rd = 1; tx_drained = 1; step();
    @(negedge clk); chk("R11", int'(thre_pend), 1);
    thr_wr = 1; tx_drained = 1; step();
    @(negedge clk); chk("R11", int'(thre_pend), 0);
    // R10: read of a non-0x2 code does not clear.
    tx_drained = 1; step(); ier_en = 4'hA; lsr_err = 4'h0; msr_delta = 4'h1;
    rx_ready = 1; ier_en = 4'hB; fifo_on = 0; iir_rd = 1; step(2);
    @(negedge clk); chk("R10", int'(thre_pend), 1);
    // R5: trigger boundaries.
    fifo_on = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      rx_count = 5'(lvl(s) - 1); step();
      @(negedge clk); chk("R5", int'(iir_data[3:0] == 4'h4), 0);
      rx_count = 5'(lvl(s)); step();
      @(negedge clk); chk("R5", int'(iir_data[3:0]), 4);
    end
    // R3/R2 priority.
    timeout_pend = 1; step();
    @(negedge clk); chk("R3", int'(iir_data[3:0]), 12);
    ier_en = 4'hF; lsr_err = 4'h8; step();
    @(negedge clk); chk("R2", int'(iir_data[3:0]), 6);
    // Random stretch.
    for (int k = 0; k < 4000; k++) begin
      ier_en = 4'($urandom);
      lsr_err = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      timeout_pend = ($urandom % 4 == 0);
      rx_ready = $urandom % 2;
      rx_count = 5'($urandom % 17);
      trig_sel = 2'($urandom);
      fifo_on = $urandom % 2;
      msr_delta = 4'($urandom);
      thr_empty = $urandom % 2;
      ier_wr = ($urandom % 4 == 0);
      thr_wr = ($urandom % 6 == 0);
      tx_drained = ($urandom % 4 == 0);
      iir_rd = ($urandom % 2 == 0);
      @(posedge clk); #1;
    end
    step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule